// File: doc/BRIEF.md
# Power-up Banner Sequencer

This block writes a fixed ASCII greeting into the write side of a UART transmit FIFO once, right after the device comes out of configuration. It needs no external reset. An internal counter holds the logic in reset for a fixed number of clocks. The release of that reset yields a start pulse exactly one cycle wide, which loads the character index with the first message position. From then on the block offers one byte at a time. It holds back whenever sending is disabled or the FIFO reports full. A message longer than the FIFO is deep therefore arrives complete and in order, and never wraps over its own first character.

The message is a constant table of `MSG_LEN` bytes, computed at elaboration. Character i is the ASCII code 0x41 + (i mod 26), so the message reads "ABC…Z" and then starts again at "A". The write side follows valid/ready rules, where ready is the inverse of `fifo_full`. `wr_valid` is raised only in a cycle where `fifo_full` is low, so every cycle with `wr_valid` high is one accepted write of `wr_data`. When `fifo_full` is high the byte is simply held, and it is offered again once room appears. `done` shows that the whole message has been handed over.

Top module: `boot_banner_tx`

## Requirements
- R1: After power-up the internal reset stays active for `POR_CYCLES` (16) clocks. `wr_valid` and `done` stay low during that time. With `send_en` held high, the first write appears in the cycle that follows the 17th rising clock edge.
- R2: The reset counter saturates at its final value. The reset is released exactly once and never asserts again. The start pulse is high for exactly one cycle.
- R3: `wr_valid` is never high while `send_en` is low. Lowering `send_en` in the middle of the message pauses it without loss.
- R4: `wr_valid` is never high in a cycle where `fifo_full` is high.
- R5: `wr_valid` is never high in two consecutive cycles.
- R6: The bytes written are the message characters in index order. Character i equals 0x41 + (i mod 26), each is written exactly once, and the index advances only on an accepted write.
- R7: Exactly `MSG_LEN` writes are made. After the last one, `wr_valid` stays low.
- R8: `done` rises in the cycle right after the final write and stays high from then on.
- R9: Messages of 16, 17 and 32 characters pass through a 16-entry FIFO complete and in order, with the first character first, even while the FIFO is filled to capacity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| send_en | input | 1 | Permits writes while high |
| fifo_full | input | 1 | FIFO full flag; acts as the inverse of ready |
| wr_valid | output | 1 | Write strobe; each high cycle is one accepted byte |
| wr_data | output | 8 | ASCII code of the current character |
| done | output | 1 | High once the last character has been written |

## Verification
The checker watches, on every cycle, the rules that hold locally in time. The start pulse is one cycle wide and the reset never returns. Writes are quiet during reset, when disabled, when the FIFO is full and after completion. Writes are never back-to-back, and `done` never falls. Only the bench scenarios can show the properties that need the whole message. These are the byte order as drained from a modelled 16-entry FIFO, the exact write count, the timing of the first write and of `done`, and the absence of rotation or loss for messages of 1, 15, 16, 17 and 32 characters. The 32-character run also pauses the message by lowering `send_en`.

// File: rtl/banner_pkg.sv
package banner_pkg;
  localparam int unsigned CHAR_W = 8;

  // Message character at position i: cycles through 'A'..'Z'.
  function automatic logic [CHAR_W-1:0] banner_byte(int unsigned i);
    return CHAR_W'(32'd65 + (i % 32'd26));
  endfunction
endpackage

// File: rtl/banner_por.sv
// Power-on reset generator: a counter that saturates, plus a delayed copy of
// the reset whose falling edge gives a one-cycle start pulse.
module banner_por #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  output logic por_act,
  output logic start_p
);
  localparam int unsigned CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] TOP = CW'(HOLD - 1);

  logic [CW-1:0] cnt   = '0;
  logic          rst_q = 1'b1;
  logic          rst_d = 1'b1;

  always_ff @(posedge clk) begin
    if (cnt != TOP) cnt <= cnt + 1'b1;
    rst_q <= (cnt != TOP);
    rst_d <= rst_q;
  end

  assign por_act = rst_q;
  assign start_p = !rst_q && rst_d;
endmodule

// File: rtl/banner_rom.sv
// Constant message table, built at elaboration from the package function.
module banner_rom #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic [IW-1:0]                   addr,
  output logic [banner_pkg::CHAR_W-1:0]   data
);
  logic [banner_pkg::CHAR_W-1:0] tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_tbl
    assign tbl[g] = banner_pkg::banner_byte(g);
  end

  assign data = tbl[addr];
endmodule

// File: rtl/banner_seq.sv
// Character index and write pacing. A strobe is offered only when sending is
// enabled, the FIFO has room and no strobe was issued in the previous cycle.
module banner_seq #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          start_p,
  input  logic          send_en,
  input  logic          fifo_full,
  output logic [IW-1:0] idx,
  output logic          wr_valid,
  output logic          done
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic sending = 1'b0;
  logic gap     = 1'b0;
  logic [IW-1:0] idx_q = '0;
  logic done_q  = 1'b0;

  assign wr_valid = sending && send_en && !fifo_full && !gap;

  always_ff @(posedge clk) begin
    gap <= wr_valid;
    if (start_p) begin
      idx_q   <= '0;
      sending <= 1'b1;
      done_q  <= 1'b0;
    end else if (wr_valid) begin
      if (idx_q == LAST) begin
        sending <= 1'b0;
        done_q  <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign idx  = idx_q;
  assign done = done_q;
endmodule

// File: rtl/boot_banner_tx.sv
module boot_banner_tx #(
  parameter int unsigned MSG_LEN    = 16,
  parameter int unsigned POR_CYCLES = 16
) (
  input  logic       clk,
  input  logic       send_en,
  input  logic       fifo_full,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       done
);
  localparam int unsigned IW = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1;

  logic          por_act;
  logic          start_p;
  logic [IW-1:0] idx;

  banner_por #(.HOLD(POR_CYCLES)) u_por (
    .clk     (clk),
    .por_act (por_act),
    .start_p (start_p)
  );

  banner_seq #(.N(MSG_LEN), .IW(IW)) u_seq (
    .clk       (clk),
    .start_p   (start_p),
    .send_en   (send_en),
    .fifo_full (fifo_full),
    .idx       (idx),
    .wr_valid  (wr_valid),
    .done      (done)
  );

  banner_rom #(.N(MSG_LEN), .IW(IW)) u_rom (
    .addr (idx),
    .data (wr_data)
  );
endmodule

// File: rtl/banner_tx_chk.sv
module banner_tx_chk (
  input logic clk,
  input logic por_act,
  input logic start_p,
  input logic send_en,
  input logic fifo_full,
  input logic wr_valid,
  input logic done
);
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    por_act |-> (!wr_valid && !done));

  p_start_one_cycle_r2: assert property (@(posedge clk)
    start_p |=> !start_p);

  p_no_rerelease_r2: assert property (@(posedge clk)
    !por_act |=> !por_act);

  p_gate_enable_r3: assert property (@(posedge clk) disable iff (por_act)
    wr_valid |-> send_en);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (por_act)
    wr_valid |-> !fifo_full);

  p_spacing_r5: assert property (@(posedge clk) disable iff (por_act)
    wr_valid |=> !wr_valid);

  p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (por_act)
    done |-> !wr_valid);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (por_act)
    done |=> done);
endmodule

bind boot_banner_tx banner_tx_chk u_chk (
  .clk       (clk),
  .por_act   (por_act),
  .start_p   (start_p),
  .send_en   (send_en),
  .fifo_full (fifo_full),
  .wr_valid  (wr_valid),
  .done      (done)
);

// File: tb/boot_banner_tx_test.sv
`timescale 1ns/1ps
// One design instance with a 16-deep FIFO model drained slowly.
module banner_lane #(
  parameter int LEN   = 16,
  parameter int DRAIN = 20
) (
  input  logic clk,
  input  logic go,
  output int   o_strobe, o_recv, o_bad, o_ovf, o_b2b, o_off,
  output int   o_peak, o_first, o_last, o_done_cyc, o_drop
);
  logic       full = 1'b0;
  logic       wv;
  logic [7:0] wd;
  logic       dn;

  boot_banner_tx #(.MSG_LEN(LEN)) uut (
    .clk (clk), .send_en (go), .fifo_full (full),
    .wr_valid (wv), .wr_data (wd), .done (dn)
  );

  function automatic logic [7:0] exp_byte(int i);
    return 8'(65 + (i % 26));
  endfunction

  logic [7:0] mem [16];
  int n_strobe = 0, n_recv = 0, n_bad = 0, n_ovf = 0, n_b2b = 0, n_off = 0;
  int peak = 0, first_cyc = -1, last_cyc = -1, done_cyc = -1, n_drop = 0;
  int wp = 0, rp = 0, cnt = 0, cyc = 0, dcnt = 0;
  logic s_w = 1'b0, prev_w = 1'b0, prev_dn = 1'b0;
  logic [7:0] s_d = 8'h00;

  always @(negedge clk) begin
    s_w = wv;
    s_d = wd;
    if (wv) begin
      n_strobe++;
      if (first_cyc < 0) first_cyc = cyc;
      last_cyc = cyc;
      if (full)   n_ovf++;
      if (prev_w) n_b2b++;
      if (!go)    n_off++;
    end
    prev_w = wv;
    if (dn && done_cyc < 0) done_cyc = cyc;
    if (prev_dn && !dn) n_drop++;
    prev_dn = dn;
  end

  always @(posedge clk) begin
    cyc++;
    if (s_w && cnt < 16) begin
      mem[wp] = s_d;
      wp = (wp + 1) % 16;
      cnt++;
    end
    s_w = 1'b0;
    dcnt++;
    if (dcnt >= DRAIN && cnt > 0) begin
      dcnt = 0;
      if (n_recv >= LEN || mem[rp] != exp_byte(n_recv)) n_bad++;
      n_recv++;
      rp = (rp + 1) % 16;
      cnt--;
    end
    if (cnt > peak) peak = cnt;
    full <= (cnt == 16);
  end

  assign o_strobe = n_strobe;  assign o_recv = n_recv;  assign o_bad = n_bad;
  assign o_ovf = n_ovf;        assign o_b2b = n_b2b;    assign o_off = n_off;
  assign o_peak = peak;        assign o_first = first_cyc;
  assign o_last = last_cyc;    assign o_done_cyc = done_cyc;
  assign o_drop = n_drop;
endmodule

module boot_banner_tx_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  logic g1 = 1'b1, g15 = 1'b0, g16 = 1'b0, g17 = 1'b0, g32 = 1'b0;
  int s1[11], s15[11], s16[11], s17[11], s32[11];

  banner_lane #(.LEN(1)) l1 (.clk(clk), .go(g1),
    .o_strobe(s1[0]), .o_recv(s1[1]), .o_bad(s1[2]), .o_ovf(s1[3]), .o_b2b(s1[4]),
    .o_off(s1[5]), .o_peak(s1[6]), .o_first(s1[7]), .o_last(s1[8]),
    .o_done_cyc(s1[9]), .o_drop(s1[10]));
  banner_lane #(.LEN(15)) l15 (.clk(clk), .go(g15),
    .o_strobe(s15[0]), .o_recv(s15[1]), .o_bad(s15[2]), .o_ovf(s15[3]), .o_b2b(s15[4]),
    .o_off(s15[5]), .o_peak(s15[6]), .o_first(s15[7]), .o_last(s15[8]),
    .o_done_cyc(s15[9]), .o_drop(s15[10]));
  banner_lane #(.LEN(16)) l16 (.clk(clk), .go(g16),
    .o_strobe(s16[0]), .o_recv(s16[1]), .o_bad(s16[2]), .o_ovf(s16[3]), .o_b2b(s16[4]),
    .o_off(s16[5]), .o_peak(s16[6]), .o_first(s16[7]), .o_last(s16[8]),
    .o_done_cyc(s16[9]), .o_drop(s16[10]));
  banner_lane #(.LEN(17)) l17 (.clk(clk), .go(g17),
    .o_strobe(s17[0]), .o_recv(s17[1]), .o_bad(s17[2]), .o_ovf(s17[3]), .o_b2b(s17[4]),
    .o_off(s17[5]), .o_peak(s17[6]), .o_first(s17[7]), .o_last(s17[8]),
    .o_done_cyc(s17[9]), .o_drop(s17[10]));
  banner_lane #(.LEN(32)) uut (.clk(clk), .go(g32),
    .o_strobe(s32[0]), .o_recv(s32[1]), .o_bad(s32[2]), .o_ovf(s32[3]), .o_b2b(s32[4]),
    .o_off(s32[5]), .o_peak(s32[6]), .o_first(s32[7]), .o_last(s32[8]),
    .o_done_cyc(s32[9]), .o_drop(s32[10]));

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Checks shared by every length once its message has drained.
  task automatic judge(int len, int st[11]);
    chk(st[0] == len, $sformatf("R7 len%0d strobe count", len), st[0], len);
    chk(st[1] == len, $sformatf("R9 len%0d bytes drained", len), st[1], len);
    chk(st[2] == 0,   $sformatf("R6 len%0d order mismatches", len), st[2], 0);
    chk(st[3] == 0,   $sformatf("R4 len%0d write while full", len), st[3], 0);
    chk(st[4] == 0,   $sformatf("R5 len%0d back-to-back", len), st[4], 0);
    chk(st[5] == 0,   $sformatf("R3 len%0d write while disabled", len), st[5], 0);
    chk(st[9] == st[8] + 1, $sformatf("R8 len%0d done timing", len), st[9], st[8] + 1);
    chk(st[10] == 0,  $sformatf("R8 len%0d done dropped", len), st[10], 0);
  endtask

  task automatic t_reset_idle();
    repeat (10) @(negedge clk);
    chk(s1[0] + s15[0] + s16[0] + s17[0] + s32[0] == 0, "R1 no write in reset",
        s1[0] + s15[0] + s16[0] + s17[0] + s32[0], 0);
    chk(s1[9] < 0 && s32[9] < 0, "R1 done low in reset", s1[9], -1);
  endtask

  task automatic t_len1();
    int t = 0;
    while (s1[1] < 1 && t < 2000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    chk(s1[7] == 17, "R1 first write cycle", s1[7], 17);
    judge(1, s1);
  endtask

  task automatic t_len15();
    int t = 0;
    g15 = 1'b1;
    while (s15[1] < 15 && t < 2000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    judge(15, s15);
  endtask

  task automatic t_len16();
    int t = 0;
    g16 = 1'b1;
    while (s16[1] < 16 && t < 2000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    judge(16, s16);
  endtask

  task automatic t_len17();
    int t = 0;
    g17 = 1'b1;
    while (s17[1] < 17 && t < 2000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    judge(17, s17);
  endtask

  task automatic t_len32_pause();
    int t = 0;
    int held;
    g32 = 1'b1;
    while (s32[0] < 8 && t < 2000) begin @(negedge clk); t++; end
    g32 = 1'b0;
    held = s32[0];
    repeat (30) @(negedge clk);
    chk(s32[0] == held, "R3 paused message makes no write", s32[0], held);
    g32 = 1'b1;
    t = 0;
    while (s32[1] < 32 && t < 4000) begin @(negedge clk); t++; end
    repeat (5) @(negedge clk);
    chk(s32[6] == 16, "R9 len32 FIFO filled to depth", s32[6], 16);
    judge(32, s32);
    repeat (40) @(negedge clk);
    chk(s32[0] == 32, "R7 len32 quiet after done", s32[0], 32);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_len1();
    t_len15();
    t_len16();
    t_len17();
    t_len32_pause();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule